// File: doc/BRIEF.md
# Three-Wire Synthesizer Register Loader

This block takes configuration words for a dual-channel frequency synthesizer over a three-wire serial link: data, serial clock and a load strobe. All three inputs pass through synchronizers into the system clock. A rising serial clock edge shifts one bit into a single shared shift register. A rising edge of the load strobe copies that register into one of four holding latches. The two lowest register bits are the control bits, and they pick the latch: the reference divider or the main divider, for either the transmit or the receive channel.

Words are sent most significant bit first, so the last two bits sent are the control bits. The two kinds of word lay out their fields differently. A reference word, counted upward from bit 0, holds the two control bits, two test bits, a 14-bit divide value, one charge-pump current select bit, and four ignored bits, for 23 bits in all. A main word holds the two control bits, a 7-bit swallow count, and an 11-bit main count, and is 20 bits long. Each latch drives its fields straight to the synthesizer. A flag reports any divide value that is below the legal minimum, and the value is still latched as written.

Top module: `synthCfgLoader`

## Requirements
- R1: On each synchronized rising edge of `serClk`, the current `serData` bit enters shift bit 0 and older bits move up one place. A falling edge, or no edge, leaves the register unchanged.
- R2: Shift bit 0 is CN1 and shift bit 1 is CN2. The value {CN2,CN1} selects the latch: 0 is transmit reference, 1 is receive reference, 2 is transmit main, 3 is receive main.
- R3: A reference load writes three fields. Bits 3:2 go to the test bits, with T2 in bit 1 of the field. Bits 17:4 go to the 14-bit divide value. Bit 18 goes to the pump select. Bits 22:19 have no effect on any output.
- R4: A main load writes two fields. Bits 8:2 go to the 7-bit swallow count and bits 19:9 go to the 11-bit main count.
- R5: A load leaves the three latches it does not address unchanged.
- R6: A latch updates once for each rising edge of `loadEn`. While `loadEn` stays high, shifting in a new word updates nothing.
- R7: `*RefLow` is high when that channel's reference divide value is below 3. `*MainLow` is high when that channel's main count is below 3. The value is latched unchanged in both cases.
- R8: A serial clock edge and a load edge can arrive in the same cycle. The load then uses the register contents from before that shift, and the new bit is still shifted in.
- R9: After reset, every latch field is 0, so all four low flags are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| serClk | input | 1 | Serial shift clock (asynchronous) |
| serData | input | 1 | Serial data, MSB first |
| loadEn | input | 1 | Load strobe, acts on its rising edge |
| txRefDiv | output | 14 | Transmit reference divide value |
| txTestBits | output | 2 | Transmit test bits {T2,T1} |
| txPumpSel | output | 1 | Transmit charge-pump current select |
| txMainCnt | output | 11 | Transmit main count |
| txSwallowCnt | output | 7 | Transmit swallow count |
| txRefLow | output | 1 | Transmit reference divide value below 3 |
| txMainLow | output | 1 | Transmit main count below 3 |
| rxRefDiv | output | 14 | Receive reference divide value |
| rxTestBits | output | 2 | Receive test bits {T2,T1} |
| rxPumpSel | output | 1 | Receive charge-pump current select |
| rxMainCnt | output | 11 | Receive main count |
| rxSwallowCnt | output | 7 | Receive swallow count |
| rxRefLow | output | 1 | Receive reference divide value below 3 |
| rxMainLow | output | 1 | Receive main count below 3 |

## Verification
The shift of a serial bit and the capture into a latch can fall in the same system cycle. The bench provokes this by raising `serClk` and `loadEn` in the same time step. Both pass through identical synchronizers, so their edges are detected together. The latched fields are judged against the word that was in the register before that bit arrived. A second load that follows without any shift is then judged against the register with the extra bit in it, which changes the address it decodes to.

// File: rtl/synthCfgPkg.sv
package synthCfgPkg;
  localparam int NUM_CH     = 2;
  localparam int NUM_LATCH  = 2 * NUM_CH;
  localparam int SHIFT_W    = 23;
  localparam int CN_W       = 2;
  localparam int TEST_W     = 2;
  localparam int REF_W      = 14;
  localparam int SWAL_W     = 7;
  localparam int MAIN_W     = 11;
  localparam int TEST_LSB   = CN_W;
  localparam int REF_LSB    = TEST_LSB + TEST_W;
  localparam int PUMP_POS   = REF_LSB + REF_W;
  localparam int SWAL_LSB   = CN_W;
  localparam int MAIN_LSB   = SWAL_LSB + SWAL_W;

  typedef struct packed {
    logic               shiftEn;
    logic [NUM_LATCH-1:0] loadSel;
  } cfgStrobe_t;

  typedef struct packed {
    logic [TEST_W-1:0] test;
    logic [REF_W-1:0]  div;
    logic              pump;
  } refFields_t;

  typedef struct packed {
    logic [MAIN_W-1:0] cnt;
    logic [SWAL_W-1:0] swallow;
  } mainFields_t;
endpackage

// File: rtl/cfgSync.sv
module cfgSync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= '0;
    else       chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/cfgLoaderCtrl.sv
module cfgLoaderCtrl
  import synthCfgPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            serClkRaw,
  input  logic            serDataRaw,
  input  logic            loadEnRaw,
  input  logic [CN_W-1:0] cnBits,
  output cfgStrobe_t      strb,
  output logic            dataBit
);
  localparam int NUM_IN = 3;

  logic [NUM_IN-1:0] rawIn;
  logic [NUM_IN-1:0] syncIn;
  logic clkPrev;
  logic lePrev;
  logic clkEdge;
  logic loadEdge;

  assign rawIn = {loadEnRaw, serDataRaw, serClkRaw};

  for (genvar i = 0; i < NUM_IN; i++) begin : g_sync
    cfgSync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk (clk),
      .rstN(rstN),
      .d   (rawIn[i]),
      .q   (syncIn[i])
    );
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkPrev <= 1'b0;
      lePrev  <= 1'b0;
    end else begin
      clkPrev <= syncIn[0];
      lePrev  <= syncIn[2];
    end
  end

  assign clkEdge  = syncIn[0] & ~clkPrev;
  assign loadEdge = syncIn[2] & ~lePrev;
  assign dataBit  = syncIn[1];

  always_comb begin
    strb.shiftEn = clkEdge;
    strb.loadSel = '0;
    if (loadEdge) strb.loadSel = NUM_LATCH'(1) << cnBits;
  end

  AST_LOAD_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strb.loadSel)); // R2
  AST_SINGLE_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (strb.loadSel != '0) |=> (strb.loadSel == '0)); // R6
endmodule

// File: rtl/cfgLoaderPath.sv
module cfgLoaderPath
  import synthCfgPkg::*;
#(
  parameter int REF_MIN  = 3,
  parameter int MAIN_MIN = 3
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  cfgStrobe_t              strb,
  input  logic                    dataBit,
  output logic [CN_W-1:0]         cnBits,
  output refFields_t [NUM_CH-1:0] refQ,
  output mainFields_t [NUM_CH-1:0] mainQ,
  output logic [NUM_CH-1:0]       refLow,
  output logic [NUM_CH-1:0]       mainLow
);
  logic [SHIFT_W-1:0] shiftReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             shiftReg <= '0;
    else if (strb.shiftEn) shiftReg <= {shiftReg[SHIFT_W-2:0], dataBit};
  end

  assign cnBits = shiftReg[CN_W-1:0];

  AST_SHIFT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.shiftEn |=> $stable(shiftReg)); // R1
  AST_SHIFT_IN: assert property (@(posedge clk) disable iff (!rstN)
    strb.shiftEn |=> (shiftReg[0] == $past(dataBit))); // R1

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        refQ[ch] <= '0;
      end else if (strb.loadSel[ch]) begin
        refQ[ch].test <= shiftReg[TEST_LSB +: TEST_W];
        refQ[ch].div  <= shiftReg[REF_LSB +: REF_W];
        refQ[ch].pump <= shiftReg[PUMP_POS];
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        mainQ[ch] <= '0;
      end else if (strb.loadSel[NUM_CH + ch]) begin
        mainQ[ch].swallow <= shiftReg[SWAL_LSB +: SWAL_W];
        mainQ[ch].cnt     <= shiftReg[MAIN_LSB +: MAIN_W];
      end
    end

    assign refLow[ch]  = (32'(refQ[ch].div) < REF_MIN);
    assign mainLow[ch] = (32'(mainQ[ch].cnt) < MAIN_MIN);

    AST_REF_KEEP: assert property (@(posedge clk) disable iff (!rstN)
      !strb.loadSel[ch] |=> $stable(refQ[ch])); // R5
    AST_MAIN_KEEP: assert property (@(posedge clk) disable iff (!rstN)
      !strb.loadSel[NUM_CH + ch] |=> $stable(mainQ[ch])); // R5
    AST_REF_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
      strb.loadSel[ch] |=> (refQ[ch].div == $past(shiftReg[REF_LSB +: REF_W]))); // R3 R8
    AST_MAIN_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
      strb.loadSel[NUM_CH + ch] |=> (mainQ[ch].cnt == $past(shiftReg[MAIN_LSB +: MAIN_W]))); // R4 R8
  end
endmodule

// File: rtl/synthCfgLoader.sv
module synthCfgLoader
  import synthCfgPkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int REF_MIN     = 3,
  parameter int MAIN_MIN    = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              serClk,
  input  logic              serData,
  input  logic              loadEn,
  output logic [REF_W-1:0]  txRefDiv,
  output logic [TEST_W-1:0] txTestBits,
  output logic              txPumpSel,
  output logic [MAIN_W-1:0] txMainCnt,
  output logic [SWAL_W-1:0] txSwallowCnt,
  output logic              txRefLow,
  output logic              txMainLow,
  output logic [REF_W-1:0]  rxRefDiv,
  output logic [TEST_W-1:0] rxTestBits,
  output logic              rxPumpSel,
  output logic [MAIN_W-1:0] rxMainCnt,
  output logic [SWAL_W-1:0] rxSwallowCnt,
  output logic              rxRefLow,
  output logic              rxMainLow
);
  cfgStrobe_t               strb;
  logic                     dataBit;
  logic [CN_W-1:0]          cnBits;
  refFields_t [NUM_CH-1:0]  refQ;
  mainFields_t [NUM_CH-1:0] mainQ;
  logic [NUM_CH-1:0]        refLow;
  logic [NUM_CH-1:0]        mainLow;

  cfgLoaderCtrl #(.SYNC_STAGES(SYNC_STAGES)) i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .serClkRaw (serClk),
    .serDataRaw(serData),
    .loadEnRaw (loadEn),
    .cnBits    (cnBits),
    .strb      (strb),
    .dataBit   (dataBit)
  );

  cfgLoaderPath #(.REF_MIN(REF_MIN), .MAIN_MIN(MAIN_MIN)) i_path (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .dataBit(dataBit),
    .cnBits (cnBits),
    .refQ   (refQ),
    .mainQ  (mainQ),
    .refLow (refLow),
    .mainLow(mainLow)
  );

  assign txRefDiv     = refQ[0].div;
  assign txTestBits   = refQ[0].test;
  assign txPumpSel    = refQ[0].pump;
  assign txMainCnt    = mainQ[0].cnt;
  assign txSwallowCnt = mainQ[0].swallow;
  assign txRefLow     = refLow[0];
  assign txMainLow    = mainLow[0];
  assign rxRefDiv     = refQ[1].div;
  assign rxTestBits   = refQ[1].test;
  assign rxPumpSel    = refQ[1].pump;
  assign rxMainCnt    = mainQ[1].cnt;
  assign rxSwallowCnt = mainQ[1].swallow;
  assign rxRefLow     = refLow[1];
  assign rxMainLow    = mainLow[1];
endmodule

// File: tb/test_synthCfgLoader.sv
module test_synthCfgLoader;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic serClk = 1'b0;
  logic serData = 1'b0;
  logic loadEn = 1'b0;
  logic [13:0] txRefDiv, rxRefDiv;
  logic [1:0]  txTestBits, rxTestBits;
  logic        txPumpSel, rxPumpSel;
  logic [10:0] txMainCnt, rxMainCnt;
  logic [6:0]  txSwallowCnt, rxSwallowCnt;
  logic        txRefLow, txMainLow, rxRefLow, rxMainLow;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [22:0] expShift = '0;
  int expDiv[2], expTest[2], expPump[2], expCnt[2], expSwal[2];

  always #2 clk = ~clk;

  synthCfgLoader i_synthCfgLoader (
    .clk(clk), .rstN(rstN), .serClk(serClk), .serData(serData), .loadEn(loadEn),
    .txRefDiv(txRefDiv), .txTestBits(txTestBits), .txPumpSel(txPumpSel),
    .txMainCnt(txMainCnt), .txSwallowCnt(txSwallowCnt),
    .txRefLow(txRefLow), .txMainLow(txMainLow),
    .rxRefDiv(rxRefDiv), .rxTestBits(rxTestBits), .rxPumpSel(rxPumpSel),
    .rxMainCnt(rxMainCnt), .rxSwallowCnt(rxSwallowCnt),
    .rxRefLow(rxRefLow), .rxMainLow(rxMainLow)
  );

  task automatic waitClk(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic checkVal(input string tag, input int actual, input int expected);
    checks++;
    if (actual !== expected) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, actual, expected);
    end
  endtask

  task automatic checkAll(input string tag);
    checkVal({tag, " R3 txRefDiv"}, int'(txRefDiv), expDiv[0]);
    checkVal({tag, " R3 txTestBits"}, int'(txTestBits), expTest[0]);
    checkVal({tag, " R3 txPumpSel"}, int'(txPumpSel), expPump[0]);
    checkVal({tag, " R4 txMainCnt"}, int'(txMainCnt), expCnt[0]);
    checkVal({tag, " R4 txSwallowCnt"}, int'(txSwallowCnt), expSwal[0]);
    checkVal({tag, " R3 rxRefDiv"}, int'(rxRefDiv), expDiv[1]);
    checkVal({tag, " R3 rxTestBits"}, int'(rxTestBits), expTest[1]);
    checkVal({tag, " R3 rxPumpSel"}, int'(rxPumpSel), expPump[1]);
    checkVal({tag, " R4 rxMainCnt"}, int'(rxMainCnt), expCnt[1]);
    checkVal({tag, " R4 rxSwallowCnt"}, int'(rxSwallowCnt), expSwal[1]);
    checkVal({tag, " R7 txRefLow"}, int'(txRefLow), int'(expDiv[0] < 3));
    checkVal({tag, " R7 rxRefLow"}, int'(rxRefLow), int'(expDiv[1] < 3));
    checkVal({tag, " R7 txMainLow"}, int'(txMainLow), int'(expCnt[0] < 3));
    checkVal({tag, " R7 rxMainLow"}, int'(rxMainLow), int'(expCnt[1] < 3));
  endtask

  // Model of a load: address {CN2,CN1} in shift bits 1:0 (R2)
  task automatic modelLoad();
    int addr;
    int ch;
    addr = int'(expShift[1:0]);
    ch = addr % 2;
    if (addr < 2) begin
      expTest[ch] = int'(expShift[3:2]);
      expDiv[ch]  = int'(expShift[17:4]);
      expPump[ch] = int'(expShift[18]);
    end else begin
      expSwal[ch] = int'(expShift[8:2]);
      expCnt[ch]  = int'(expShift[19:9]);
    end
  endtask

  task automatic sendBit(input logic b);
    serData = b;
    waitClk(4);
    serClk = 1'b1;
    waitClk(6);
    serClk = 1'b0;
    waitClk(6);
    expShift = {expShift[21:0], b};
  endtask

  task automatic sendWord(input logic [22:0] w, input int len);
    for (int i = len - 1; i >= 0; i--) sendBit(w[i]);
  endtask

  task automatic pulseLoad();
    loadEn = 1'b1;
    waitClk(6);
    loadEn = 1'b0;
    waitClk(6);
    modelLoad();
  endtask

  function automatic logic [22:0] refWord(int addr, int test, int dv, int pump, int dc);
    return {4'(dc), 1'(pump), 14'(dv), 2'(test), 2'(addr)};
  endfunction

  function automatic logic [22:0] mainWord(int addr, int cnt, int swal);
    return {3'b000, 11'(cnt), 7'(swal), 2'(addr)};
  endfunction

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < 2; c++) begin
      expDiv[c] = 0; expTest[c] = 0; expPump[c] = 0; expCnt[c] = 0; expSwal[c] = 0;
    end
    waitClk(3);
    rstN = 1'b1;
    waitClk(2);
    checkAll("R9 reset");

    // Sweep every address with boundary and spread values (R1 R2 R3 R4 R5 R7)
    for (int k = 0; k < 6; k++) begin
      for (int addr = 0; addr < 4; addr++) begin
        int dv;
        int cnt;
        dv  = (k == 0) ? 0 : (k == 1) ? 2 : (k == 2) ? 3 : (k == 3) ? 16383
              : (k * 2731 + addr * 97) % 16384;
        cnt = (k == 0) ? 1 : (k == 1) ? 2 : (k == 2) ? 3 : (k == 3) ? 2047
              : (k * 389 + addr * 53) % 2048;
        if (addr < 2) sendWord(refWord(addr, k % 4, dv, k % 2, (k % 2) * 15), 23);
        else          sendWord(mainWord(addr, cnt, (k * 37 + addr) % 128), 20);
        pulseLoad();
        checkAll("R2 R5 sweep");
      end
    end

    // R6: held load enable does not reload
    sendWord(refWord(0, 1, 1234, 1, 0), 23);
    pulseLoad();
    loadEn = 1'b1;
    waitClk(6);
    modelLoad();
    sendWord(refWord(0, 2, 4321, 0, 0), 23);
    checkVal("R6 held txRefDiv", int'(txRefDiv), 1234);
    loadEn = 1'b0;
    waitClk(6);
    checkVal("R6 after fall txRefDiv", int'(txRefDiv), 1234);
    pulseLoad();
    checkVal("R6 new edge txRefDiv", int'(txRefDiv), 4321);
    checkAll("R6");

    // R8: serial edge and load edge together
    sendWord(mainWord(2, 777, 55), 20);
    serData = 1'b1;
    waitClk(6);
    serClk = 1'b1;
    loadEn = 1'b1;
    waitClk(6);
    modelLoad();
    expShift = {expShift[21:0], 1'b1};
    serClk = 1'b0;
    loadEn = 1'b0;
    waitClk(6);
    checkVal("R8 txMainCnt", int'(txMainCnt), 777);
    checkVal("R8 txSwallowCnt", int'(txSwallowCnt), 55);
    pulseLoad();
    checkAll("R8 followup");

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule